// File: doc/BRIEF.md
# Status Pin Output Selector

This block drives one open-drain status pin of a tuner control chip. A 3-bit selector code, written through a strobe, picks what the pin reports while the serial port is idle. The choices are a released pin, the PLL unlock flag, a sticky count-done flag, or the level of one of two shared I/O pins. The pin is modelled as an active-high pull-low enable: 1 drives the pin low and 0 releases it.

The block also handles the serial port overrides. While chip-enable is high and the port is in a write (input) mode, the pin is released. While chip-enable is high in read (output) mode, the pin carries the serial read data. That data is captured when chip-enable rises and again on each falling edge of the serial clock.

Chip-enable, the serial clock and the two I/O pin levels are asynchronous and pass through synchronizers. The PLL, the IF counter and the serial shift register are outside the block. They are reached through level and strobe inputs in the system clock domain.

Top module: `dosel_status_pin`

## Requirements
- R1: After reset the selector code is 000, the count-done flag is clear and `pin_pull_lo` is 0.
- R2: With chip-enable low, selector codes 000, 011, 110 and 111 keep `pin_pull_lo` at 0 whatever the other inputs do.
- R3: With chip-enable low and code 001, `pin_pull_lo` equals `pll_unlock` one clock later.
- R4: With code 010, `pin_pull_lo` shows the count-done flag. A one-cycle `cnt_end` strobe sets the flag. A 0-to-1 change of `cnt_en` clears it. A falling `cnt_en` does nothing. When the clear and the strobe land in the same cycle, the clear wins. The flag is kept under any code.
- R5: A rising synchronized chip-enable clears the count-done flag, and the flag stays clear after chip-enable falls again.
- R6: With chip-enable low, code 100 gives `pin_pull_lo = !io_pin[0]` and code 101 gives `pin_pull_lo = !io_pin[1]`, provided that I/O is configured as an input (`io_dir` bit = 0).
- R7: With code 100 or 101, when the chosen I/O has its `io_dir` bit at 1 (output), `pin_pull_lo` is 0.
- R8: While synchronized chip-enable is high and `rd_mode` is 0 (write mode), `pin_pull_lo` is 0 regardless of code.
- R9: While synchronized chip-enable is high and `rd_mode` is 1, `pin_pull_lo` is the inverse of the read bit. The read bit is sampled from `ser_bit` at the chip-enable rise and at each synchronized falling edge of `sclk_pin`, and at no other time.
- R10: The selector code changes only in a cycle where `cfg_wr` is 1, when it takes `cfg_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Strobe that loads `cfg_code` into the selector |
| cfg_code | input | 3 | New selector code |
| io_dir | input | 2 | Per shared I/O: 1 = configured as output |
| io_pin | input | 2 | Asynchronous levels of the shared I/O pins |
| pll_unlock | input | 1 | PLL unlock flag, system-clock domain |
| cnt_en | input | 1 | IF count enable bit; its rising edge starts a count |
| cnt_end | input | 1 | One-cycle strobe at the end of a measurement period |
| ce_pin | input | 1 | Asynchronous serial chip-enable |
| sclk_pin | input | 1 | Asynchronous serial clock |
| rd_mode | input | 1 | 1 = current serial transfer is a read |
| ser_bit | input | 1 | Next serial read data bit |
| pin_pull_lo | output | 1 | 1 = pull the status pin low, 0 = release |

## Verification
The bench builds the block with the default two-stage synchronizers. It sizes every settle window from that depth, so each check samples a fully propagated, registered output. The code space is small: all eight codes are swept against every direction and level combination of both shared I/Os and both unlock values. The count-done flag is driven through set, clear, same-cycle collision and chip-enable clear sequences, and a read transfer shifts out a fixed byte pattern to check the bit latching.

// File: rtl/dosel_pkg.sv
package dosel_pkg;

    localparam int NUM_IO = 2;

    typedef enum logic [2:0] {
        SRC_OFF0   = 3'd0,
        SRC_UNLOCK = 3'd1,
        SRC_CDONE  = 3'd2,
        SRC_OFF3   = 3'd3,
        SRC_IO_A   = 3'd4,
        SRC_IO_B   = 3'd5,
        SRC_OFF6   = 3'd6,
        SRC_OFF7   = 3'd7
    } src_sel_e;

    typedef struct packed {
        src_sel_e code;
        logic     ce_prev;
        logic     sclk_prev;
        logic     pull;
    } top_state_t;

    typedef struct packed {
        logic en_prev;
        logic done;
    } cdone_state_t;

endpackage

// File: rtl/dosel_sync.sv
module dosel_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dosel_cdone.sv
module dosel_cdone
    import dosel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_en_i,
    input  logic cnt_end_i,
    input  logic ce_rise_i,
    output logic done_o
);
    cdone_state_t st_d, st_q;
    logic         start;

    always_comb begin
        st_d         = st_q;
        start        = cnt_en_i & ~st_q.en_prev;
        st_d.en_prev = cnt_en_i;
        if (start || ce_rise_i) st_d.done = 1'b0;
        else if (cnt_end_i)     st_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
endmodule

// File: rtl/dosel_rdbit.sv
module dosel_rdbit (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic ser_bit_i,
    output logic bit_o
);
    logic bit_d, bit_q;

    always_comb begin
        bit_d = bit_q;
        if (load_i) bit_d = ser_bit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b1;
        else        bit_q <= bit_d;
    end

    assign bit_o = bit_q;
endmodule

// File: rtl/dosel_mux.sv
module dosel_mux
    import dosel_pkg::*;
(
    input  src_sel_e          sel_i,
    input  logic              ce_i,
    input  logic              rd_mode_i,
    input  logic              rd_bit_i,
    input  logic              unlock_i,
    input  logic              done_i,
    input  logic [NUM_IO-1:0] io_dir_i,
    input  logic [NUM_IO-1:0] io_lvl_i,
    output logic              pull_o
);
    logic [NUM_IO-1:0] io_pull;

    generate
        for (genvar k = 0; k < NUM_IO; k++) begin : g_io
            assign io_pull[k] = ~io_dir_i[k] & ~io_lvl_i[k];
        end
    endgenerate

    always_comb begin
        pull_o = 1'b0;
        if (ce_i) begin
            pull_o = rd_mode_i ? ~rd_bit_i : 1'b0;
        end else begin
            unique case (sel_i)
                SRC_UNLOCK: pull_o = unlock_i;
                SRC_CDONE:  pull_o = done_i;
                SRC_IO_A:   pull_o = io_pull[0];
                SRC_IO_B:   pull_o = io_pull[1];
                default:    pull_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dosel_status_pin.sv
module dosel_status_pin
    import dosel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_code,
    input  logic [1:0] io_dir,
    input  logic [1:0] io_pin,
    input  logic       pll_unlock,
    input  logic       cnt_en,
    input  logic       cnt_end,
    input  logic       ce_pin,
    input  logic       sclk_pin,
    input  logic       rd_mode,
    input  logic       ser_bit,
    output logic       pin_pull_lo
);
    localparam int SYNC_W = 2 + NUM_IO;

    top_state_t        state_d, state_q;
    logic [SYNC_W-1:0] sync_out;
    logic              ce_s;
    logic              sclk_s;
    logic [NUM_IO-1:0] io_s;
    logic              ce_rise;
    logic              sclk_fall;
    logic              done_flag;
    logic              rd_bit;
    logic              pull_next;

    dosel_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({io_pin, sclk_pin, ce_pin}),
        .sync_o  (sync_out)
    );

    assign ce_s      = sync_out[0];
    assign sclk_s    = sync_out[1];
    assign io_s      = sync_out[SYNC_W-1:2];
    assign ce_rise   = ce_s & ~state_q.ce_prev;
    assign sclk_fall = ~sclk_s & state_q.sclk_prev;

    dosel_cdone u_cdone (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en_i  (cnt_en),
        .cnt_end_i (cnt_end),
        .ce_rise_i (ce_rise),
        .done_o    (done_flag)
    );

    dosel_rdbit u_rdbit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ce_rise | (ce_s & sclk_fall)),
        .ser_bit_i (ser_bit),
        .bit_o     (rd_bit)
    );

    dosel_mux u_mux (
        .sel_i     (state_q.code),
        .ce_i      (ce_s),
        .rd_mode_i (rd_mode),
        .rd_bit_i  (rd_bit),
        .unlock_i  (pll_unlock),
        .done_i    (done_flag),
        .io_dir_i  (io_dir),
        .io_lvl_i  (io_s),
        .pull_o    (pull_next)
    );

    always_comb begin
        state_d           = state_q;
        state_d.ce_prev   = ce_s;
        state_d.sclk_prev = sclk_s;
        state_d.pull      = pull_next;
        if (cfg_wr) state_d.code = src_sel_e'(cfg_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{code: SRC_OFF0, ce_prev: 1'b0, sclk_prev: 1'b0, pull: 1'b0};
        else        state_q <= state_d;
    end

    assign pin_pull_lo = state_q.pull;
endmodule

// File: rtl/dosel_chk.sv
module dosel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_s,
    input logic       rd_mode,
    input logic [2:0] code,
    input logic       pll_unlock,
    input logic [1:0] io_dir,
    input logic       cfg_wr,
    input logic       done,
    input logic       pin
);
    AST_IDLE_CODES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_s && (code == 3'd0 || code == 3'd3 || code == 3'd6 || code == 3'd7)) |=> !pin); // R2

    AST_UNLOCK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_s && code == 3'd1) |=> (pin == $past(pll_unlock))); // R3

    AST_CE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_s) |=> !done); // R5

    AST_IO_OUTPUT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_s && ((code == 3'd4 && io_dir[0]) || (code == 3'd5 && io_dir[1]))) |=> !pin); // R7

    AST_WRITE_MODE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_s && !rd_mode) |=> !pin); // R8

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(code)); // R10
endmodule

bind dosel_status_pin dosel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_s       (ce_s),
    .rd_mode    (rd_mode),
    .code       (state_q.code),
    .pll_unlock (pll_unlock),
    .io_dir     (io_dir),
    .cfg_wr     (cfg_wr),
    .done       (done_flag),
    .pin        (pin_pull_lo)
);

// File: tb/dosel_status_pin_tb.sv
module dosel_status_pin_tb;
    localparam int SETTLE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_code = 3'd0;
    logic [1:0] io_dir = 2'b00;
    logic [1:0] io_pin = 2'b11;
    logic       pll_unlock = 1'b0;
    logic       cnt_en = 1'b0;
    logic       cnt_end = 1'b0;
    logic       ce_pin = 1'b0;
    logic       sclk_pin = 1'b0;
    logic       rd_mode = 1'b0;
    logic       ser_bit = 1'b1;
    logic       pin_pull_lo;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dosel_status_pin #(.SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_code(cfg_code),
        .io_dir(io_dir), .io_pin(io_pin), .pll_unlock(pll_unlock),
        .cnt_en(cnt_en), .cnt_end(cnt_end), .ce_pin(ce_pin),
        .sclk_pin(sclk_pin), .rd_mode(rd_mode), .ser_bit(ser_bit),
        .pin_pull_lo(pin_pull_lo)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic exp, input string req);
        checks++;
        if (pin_pull_lo !== exp) begin
            errors++;
            $display("FAIL %s: pin_pull_lo=%b expected %b at %0t", req, pin_pull_lo, exp, $time);
        end
    endtask

    task automatic set_code(input logic [2:0] c);
        cfg_code = c;
        cfg_wr   = 1'b1;
        tick(1);
        cfg_wr   = 1'b0;
    endtask

    task automatic strobe_end();
        cnt_end = 1'b1;
        tick(1);
        cnt_end = 1'b0;
    endtask

    function automatic logic model(input int c, input logic [1:0] d,
                                   input logic [1:0] l, input logic u);
        case (c)
            1:       return u;
            4:       return ~d[0] & ~l[0];
            5:       return ~d[1] & ~l[1];
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] pattern;
        tick(3);
        check(1'b0, "R1 in reset");
        rst_n = 1'b1;
        pll_unlock = 1'b1;
        tick(SETTLE);
        check(1'b0, "R1 code 000 after reset");
        pll_unlock = 1'b0;
        set_code(3'd2);
        tick(SETTLE);
        check(1'b0, "R1 count-done clear after reset");

        // full sweep with chip-enable low
        for (int c = 0; c < 8; c++) begin
            set_code(3'(c));
            for (int d = 0; d < 4; d++) begin
                for (int l = 0; l < 4; l++) begin
                    for (int u = 0; u < 2; u++) begin
                        io_dir = 2'(d);
                        io_pin = 2'(l);
                        pll_unlock = u[0];
                        tick(SETTLE);
                        if (c == 1)      check(model(c, 2'(d), 2'(l), u[0]), "R3 unlock");
                        else if (c == 2) check(1'b0, "R4 idle flag");
                        else if (c == 4) check(model(c, 2'(d), 2'(l), u[0]), d[0] ? "R7 IO1 output" : "R6 IO1 level");
                        else if (c == 5) check(model(c, 2'(d), 2'(l), u[0]), d[1] ? "R7 IO2 output" : "R6 IO2 level");
                        else             check(1'b0, "R2 open code");
                    end
                end
            end
        end
        io_dir = 2'b00;
        io_pin = 2'b11;
        pll_unlock = 1'b0;

        // count-done sequences
        set_code(3'd2);
        cnt_en = 1'b1; tick(SETTLE);
        check(1'b0, "R4 after start");
        strobe_end(); tick(SETTLE);
        check(1'b1, "R4 period end");
        cnt_en = 1'b0; tick(SETTLE);
        check(1'b1, "R4 falling enable ignored");
        cnt_en = 1'b1; tick(SETTLE);
        check(1'b0, "R4 restart clears");
        cnt_en = 1'b0; tick(2);
        cnt_en = 1'b1; cnt_end = 1'b1; tick(1);
        cnt_end = 1'b0; tick(SETTLE);
        check(1'b0, "R4 clear beats set");
        set_code(3'd0);
        strobe_end(); tick(SETTLE);
        check(1'b0, "R2 flag hidden under 000");
        set_code(3'd2); tick(SETTLE);
        check(1'b1, "R4 flag kept across codes");

        // chip-enable in write mode
        rd_mode = 1'b0;
        ce_pin = 1'b1; tick(SETTLE);
        check(1'b0, "R8 write mode open");
        set_code(3'd1); pll_unlock = 1'b1; tick(SETTLE);
        check(1'b0, "R8 write mode overrides unlock");
        ce_pin = 1'b0; tick(SETTLE);
        check(1'b1, "R3 unlock after ce low");
        pll_unlock = 1'b0;
        set_code(3'd2); tick(SETTLE);
        check(1'b0, "R5 ce cleared count-done");

        // R10: code ignored without strobe
        set_code(3'd1); pll_unlock = 1'b1;
        cfg_code = 3'd0; tick(SETTLE);
        check(1'b1, "R10 no write no change");

        // read transfer
        rd_mode = 1'b1;
        ser_bit = 1'b0;
        ce_pin = 1'b1; tick(SETTLE);
        check(1'b1, "R9 first bit at ce rise");
        ser_bit = 1'b1; tick(SETTLE);
        check(1'b1, "R9 no sclk no update");
        pattern = 8'b1011_0010;
        for (int b = 7; b >= 0; b--) begin
            ser_bit = pattern[b];
            sclk_pin = 1'b1; tick(SETTLE);
            sclk_pin = 1'b0; tick(SETTLE);
            check(~pattern[b], "R9 shifted bit");
        end
        ce_pin = 1'b0; rd_mode = 1'b0; tick(SETTLE);
        check(1'b1, "R3 after read transfer");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule